// File: doc/BRIEF.md
# Width-Expansion Slave Write Gate

This block is the control logic of the slave slice in a dual-port memory whose word is wider than one 8-bit device. Several slices sit side by side to form the word, and only the master slice holds an arbiter. Every slave slice takes the master's per-side busy verdict as an input and uses it to let or hold each side's write strobe. No slice reaches its own verdict, so two slices can never lock out opposite sides and leave both processors waiting for each other.

Each side presents a chip select, a write request, an output enable, an address, write data and the incoming busy flag. All of these are active low except address and data. When a side asks for a write, its strobe stays off for a settle window of `SETTLE` clock cycles, which covers the master's worst-case arbitration time. After the window the strobe follows busy. A write that is still held when busy clears is committed exactly once. Reads are never gated. Their valid flag drops while that side is busy, so the data must then be treated as suspect. The storage is a small inferred dual-port array. The registered write strobe of each side is brought out as a port.

Top module: `wgs_slave`

## Requirements
- R1: While `rst` is high, and in the cycle after it, both `*_wr_en` and both `*_rvalid` are 0.
- R2: A side's write request is `cs_n`=0 together with `wr_n`=0. Its `wr_en` cannot rise before the request has been sampled on `SETTLE`+1 consecutive rising edges. With busy inactive, `wr_en` is high in the cycle that follows the (`SETTLE`+1)th such edge. A request released earlier leaves `wr_en` low and memory unchanged.
- R3: While a side's `busy_n` is 0, that side's `wr_en` stays 0. A request that is busy for its entire duration leaves memory unchanged.
- R4: A held request whose busy clears on edge index B (edges counted from 0 at the first request edge) raises `wr_en` after edge max(`SETTLE`, B). The location is then written with the address and data that were sampled on that edge.
- R5: However long a request is held, `wr_en` is high for exactly one cycle per request.
- R6: `cs_n`=1 disables the side: no `wr_en` and no `rvalid`. The settle count is also cleared, so a request interrupted by `cs_n`=1 restarts its full window.
- R7: A read is `cs_n`=0, `wr_n`=1 and `oe_n`=0. On the next cycle `rdata` holds the stored word at the sampled address, and `rvalid` is 1 if `busy_n` was 1.
- R8: A read sampled with `busy_n`=0 gives `rvalid`=0, while `rdata` still carries the stored word.
- R9: The two sides act independently. Simultaneous requests to different addresses both commit, each on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write request, active low (1 = read) |
| l_oe_n | input | 1 | Left read output enable, active low |
| l_busy_n | input | 1 | Left busy from master, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_wr_en | output | 1 | Left gated write strobe (registered) |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read valid |
| r_cs_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write request, active low (1 = read) |
| r_oe_n | input | 1 | Right read output enable, active low |
| r_busy_n | input | 1 | Right busy from master, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_wr_en | output | 1 | Right gated write strobe (registered) |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read valid |

## Verification
The checker watches the following on every cycle:
- No strobe appears before a full settle run of request edges.
- No strobe appears out of a busy or deselected cycle.
- At most one strobe is issued per held request.
- A read-valid flag only ever follows a free, selected cycle.

Some behaviour can only be shown by the bench's scenarios. This covers the exact cycle in which the strobe rises for each busy length, and that the committed word lands at the right address. It also covers that a busy-blocked or early-released write leaves the old contents in place, and that an interrupted select restarts the window.

// File: rtl/wgs_pkg.sv
`timescale 1ns/1ps
package wgs_pkg;
  localparam int unsigned PORTS = 2;

  typedef struct packed {
    logic sel;
    logic write;
    logic read_oe;
    logic free;
  } port_ctl_t;

  function automatic port_ctl_t decode_ctl(input logic cs_n, input logic wr_n,
                                           input logic oe_n, input logic busy_n);
    port_ctl_t c;
    c.sel     = !cs_n;
    c.write   = !wr_n;
    c.read_oe = !oe_n;
    c.free    = busy_n;
    return c;
  endfunction
endpackage

// File: rtl/wgs_port_ctrl.sv
`timescale 1ns/1ps
module wgs_port_ctrl
  import wgs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_ok
);
  localparam int unsigned CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SETTLE);

  port_ctl_t        ctl;
  logic             req;
  logic             settled;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  logic             done;

  assign ctl     = decode_ctl(cs_n, wr_n, oe_n, busy_n);
  assign req     = ctl.sel && ctl.write;
  assign settled = (cnt == CNT_FULL);
  assign fire    = req && settled && ctl.free && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      rd_ok   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (!req)          cnt <= '0;
      else if (!settled) cnt <= cnt + 1'b1;
      done  <= req && (done || fire);
      wr_en <= fire;
      if (fire) begin
        wr_addr <= addr;
        wr_data <= wdata;
      end
      rd_ok <= ctl.sel && !ctl.write && ctl.read_oe && ctl.free;
    end
  end
endmodule

// File: rtl/wgs_dp_store.sv
`timescale 1ns/1ps
module wgs_dp_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_waddr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [ADDR_W-1:0] b_raddr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_waddr] <= b_wdata;
    if (a_we) mem[a_waddr] <= a_wdata;
    a_rdata <= mem[a_raddr];
    b_rdata <= mem[b_raddr];
  end
endmodule

// File: rtl/wgs_slave.sv
`timescale 1ns/1ps
module wgs_slave
  import wgs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic              l_wr_en,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_cs_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic              r_wr_en,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  logic              cs_n_v   [PORTS];
  logic              wr_n_v   [PORTS];
  logic              oe_n_v   [PORTS];
  logic              busy_n_v [PORTS];
  logic [ADDR_W-1:0] addr_v   [PORTS];
  logic [DATA_W-1:0] wdata_v  [PORTS];
  logic              we_v     [PORTS];
  logic [ADDR_W-1:0] waddr_v  [PORTS];
  logic [DATA_W-1:0] wdat_v   [PORTS];
  logic              rok_v    [PORTS];
  logic [DATA_W-1:0] rdat_v   [PORTS];

  assign cs_n_v[0]   = l_cs_n;   assign cs_n_v[1]   = r_cs_n;
  assign wr_n_v[0]   = l_wr_n;   assign wr_n_v[1]   = r_wr_n;
  assign oe_n_v[0]   = l_oe_n;   assign oe_n_v[1]   = r_oe_n;
  assign busy_n_v[0] = l_busy_n; assign busy_n_v[1] = r_busy_n;
  assign addr_v[0]   = l_addr;   assign addr_v[1]   = r_addr;
  assign wdata_v[0]  = l_wdata;  assign wdata_v[1]  = r_wdata;

  for (genvar p = 0; p < PORTS; p++) begin : g_side
    wgs_port_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)
    ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .cs_n   (cs_n_v[p]),
      .wr_n   (wr_n_v[p]),
      .oe_n   (oe_n_v[p]),
      .busy_n (busy_n_v[p]),
      .addr   (addr_v[p]),
      .wdata  (wdata_v[p]),
      .wr_en  (we_v[p]),
      .wr_addr(waddr_v[p]),
      .wr_data(wdat_v[p]),
      .rd_ok  (rok_v[p])
    );
  end

  wgs_dp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .a_we   (we_v[0]),
    .a_waddr(waddr_v[0]),
    .a_wdata(wdat_v[0]),
    .a_raddr(addr_v[0]),
    .a_rdata(rdat_v[0]),
    .b_we   (we_v[1]),
    .b_waddr(waddr_v[1]),
    .b_wdata(wdat_v[1]),
    .b_raddr(addr_v[1]),
    .b_rdata(rdat_v[1])
  );

  assign l_wr_en  = we_v[0];
  assign r_wr_en  = we_v[1];
  assign l_rvalid = rok_v[0];
  assign r_rvalid = rok_v[1];
  assign l_rdata  = rdat_v[0];
  assign r_rdata  = rdat_v[1];
endmodule

// File: rtl/wgs_slave_chk.sv
`timescale 1ns/1ps
module wgs_slave_chk #(
  parameter int unsigned SETTLE = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cs_n,
  input logic [1:0] wr_n,
  input logic [1:0] busy_n,
  input logic [1:0] wr_en,
  input logic [1:0] rvalid
);
  localparam int unsigned RUN_W = $clog2(SETTLE + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SETTLE + 1);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic             req;
    logic [RUN_W-1:0] run;
    logic             seen;

    assign req = !cs_n[p] && !wr_n[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        run  <= '0;
        seen <= 1'b0;
      end else begin
        run  <= !req ? '0 : ((run == RUN_MAX) ? run : run + 1'b1);
        seen <= req && (seen || wr_en[p]);
      end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!wr_en[p] && !rvalid[p])); // R1
    AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (rst) wr_en[p] |-> (run == RUN_MAX)); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) wr_en[p] |-> $past(busy_n[p])); // R3
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst) wr_en[p] |-> !seen); // R5
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst) $past(cs_n[p]) |-> (!wr_en[p] && !rvalid[p])); // R6
    AST_RVALID_FREE: assert property (@(posedge clk) disable iff (rst) rvalid[p] |-> $past(busy_n[p])); // R8
  end
endmodule

bind wgs_slave wgs_slave_chk #(.SETTLE(SETTLE)) u_wgs_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  ({r_cs_n, l_cs_n}),
  .wr_n  ({r_wr_n, l_wr_n}),
  .busy_n({r_busy_n, l_busy_n}),
  .wr_en ({r_wr_en, l_wr_en}),
  .rvalid({r_rvalid, l_rvalid})
);

// File: tb/tb_wgs_slave.sv
`timescale 1ns/1ps
module tb_wgs_slave;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int S  = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cs_n [2];
  logic          wr_n [2];
  logic          oe_n [2];
  logic          bz_n [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd   [2];
  logic          wen  [2];
  logic [DW-1:0] rd   [2];
  logic          rv   [2];

  wgs_slave #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(S)) dut (
    .clk(clk), .rst(rst),
    .l_cs_n(cs_n[0]), .l_wr_n(wr_n[0]), .l_oe_n(oe_n[0]), .l_busy_n(bz_n[0]),
    .l_addr(addr[0]), .l_wdata(wd[0]), .l_wr_en(wen[0]), .l_rdata(rd[0]), .l_rvalid(rv[0]),
    .r_cs_n(cs_n[1]), .r_wr_n(wr_n[1]), .r_oe_n(oe_n[1]), .r_busy_n(bz_n[1]),
    .r_addr(addr[1]), .r_wdata(wd[1]), .r_wr_en(wen[1]), .r_rdata(rd[1]), .r_rvalid(rv[1])
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int p);
    cs_n[p] = 1; wr_n[p] = 1; oe_n[p] = 1; bz_n[p] = 1; addr[p] = '0; wd[p] = '0;
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // request held for 'hold' negedges, busy low for the first busy_e edges
  task automatic wr_seq(input int p, input int a, input int d, input int busy_e,
                        input int hold, output int rise, output int pulses);
    @(negedge clk);
    cs_n[p] = 0; wr_n[p] = 0; oe_n[p] = 1; addr[p] = AW'(a); wd[p] = DW'(d);
    bz_n[p] = (busy_e > 0) ? 1'b0 : 1'b1;
    rise = -1; pulses = 0;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (wen[p]) begin pulses++; if (rise < 0) rise = i; end
      bz_n[p] = (i >= busy_e);
    end
    idle(p);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (wen[p]) pulses++;
    end
  endtask

  task automatic rd_seq(input int p, input int a, input logic busy, output int data, output int valid);
    @(negedge clk);
    cs_n[p] = 0; wr_n[p] = 1; oe_n[p] = 0; bz_n[p] = busy; addr[p] = AW'(a);
    @(negedge clk);
    data = int'(rd[p]); valid = int'(rv[p]);
    idle(p);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rise, pulses, data, valid, d, be, hold;
    idle(0); idle(1);
    repeat (3) @(negedge clk);
    check("R1 reset l_wr_en", int'(wen[0]), 0);
    check("R1 reset r_rvalid", int'(rv[1]), 0);
    rst = 0;
    @(negedge clk);
    check("R1 post-reset l_rvalid", int'(rv[0]), 0);
    check("R1 post-reset r_wr_en", int'(wen[1]), 0);

    // R4 R5 sweep: every address via each side, varying busy length and extra hold
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        d = (a * 37 + p * 91 + 5) & 8'hFF;
        be = (a + p) % 5;
        hold = maxi(S, be) + 1 + (a % 3);
        wr_seq(p, a, d, be, hold, rise, pulses);
        model[a] = DW'(d);
        check("R4 strobe cycle", rise, maxi(S, be) + 1);
        check("R5 one strobe", pulses, 1);
        rd_seq(1 - p, a, 1'b1, data, valid);
        check("R4 stored word", data, int'(model[a]));
        check("R7 read valid", valid, 1);
      end
    end

    // R2: released before the window ends
    for (int h = 1; h <= S; h++) begin
      wr_seq(0, 3, 8'hE1, 0, h, rise, pulses);
      check("R2 early release no strobe", pulses, 0);
      rd_seq(1, 3, 1'b1, data, valid);
      check("R2 memory unchanged", data, int'(model[3]));
    end

    // R3: busy for the whole request
    wr_seq(1, 5, 8'h3C, 100, 8, rise, pulses);
    check("R3 busy blocks strobe", pulses, 0);
    rd_seq(0, 5, 1'b1, data, valid);
    check("R3 memory unchanged", data, int'(model[5]));

    // R6: deselected write request
    @(negedge clk);
    cs_n[0] = 1; wr_n[0] = 0; addr[0] = 4'd6; wd[0] = 8'h99;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (wen[0]) pulses++; end
    idle(0);
    check("R6 deselected no strobe", pulses, 0);
    rd_seq(0, 6, 1'b1, data, valid);
    check("R6 memory unchanged", data, int'(model[6]));
    // R6: deselected read
    @(negedge clk);
    cs_n[1] = 1; wr_n[1] = 1; oe_n[1] = 0; addr[1] = 4'd6;
    @(negedge clk);
    check("R6 deselected rvalid", int'(rv[1]), 0);
    idle(1);

    // R6: select interrupted restarts the window
    @(negedge clk);
    cs_n[0] = 0; wr_n[0] = 0; addr[0] = 4'd7; wd[0] = 8'h5A;
    @(negedge clk);
    cs_n[0] = 1;
    @(negedge clk);
    cs_n[0] = 0;
    rise = -1;
    for (int i = 1; i <= S + 3; i++) begin
      @(negedge clk);
      if (wen[0] && rise < 0) rise = i;
    end
    idle(0);
    model[7] = 8'h5A;
    check("R6 restarted window", rise, S + 1);

    // R8: busy read
    rd_seq(0, 9, 1'b0, data, valid);
    check("R8 busy read rvalid", valid, 0);
    check("R8 busy read data", data, int'(model[9]));
    // R7: no output enable gives no valid
    @(negedge clk);
    cs_n[1] = 0; wr_n[1] = 1; oe_n[1] = 1; addr[1] = 4'd9;
    @(negedge clk);
    check("R7 oe_n high rvalid", int'(rv[1]), 0);
    idle(1);

    // R9: simultaneous writes, different addresses and busy schedules
    @(negedge clk);
    cs_n[0] = 0; wr_n[0] = 0; addr[0] = 4'd1; wd[0] = 8'hA5; bz_n[0] = 1;
    cs_n[1] = 0; wr_n[1] = 0; addr[1] = 4'd2; wd[1] = 8'h5B; bz_n[1] = 0;
    begin
      int rl, rr;
      rl = -1; rr = -1;
      for (int i = 1; i <= 8; i++) begin
        @(negedge clk);
        if (wen[0] && rl < 0) rl = i;
        if (wen[1] && rr < 0) rr = i;
        bz_n[1] = (i >= 4);
      end
      idle(0); idle(1);
      check("R9 left strobe cycle", rl, S + 1);
      check("R9 right strobe cycle", rr, 5);
    end
    model[1] = 8'hA5; model[2] = 8'h5B;
    rd_seq(0, 2, 1'b1, data, valid);
    check("R9 right word", data, 8'h5B);
    rd_seq(1, 1, 1'b1, data, valid);
    check("R9 left word", data, 8'hA5);
    rd_seq(0, 7, 1'b1, data, valid);
    check("R6 restarted write stored", data, 8'h5A);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule